// File: doc/BRIEF.md
# Bus Glue and Wait-State Controller for a 16-bit 65xx-Family CPU

This block turns the raw bus signals of a 65xx-family CPU with a 24-bit address into the chip selects, strobes and bus-control enables that a small system needs. The CPU inputs are the address, the two valid-address qualifiers (data address valid and program address valid), read/write, the ready line and the clock phase PHI2. From these the block decodes five regions:

- a boot ROM at the top of bank 0
- an I/O page split into five 256-byte device slots
- low RAM covering the rest of bank 0
- two high memory modules

It also produces the read and write strobes, a separate pair of strobes for slow devices, the bank-address latch enable, and the enable and direction of the data-bus transceiver.

A select is asserted only when the CPU flags a real access. During internal-operation cycles, when both valid-address qualifiers are low, no device is selected and no wait state is taken. Slow devices are the ROM and two of the I/O slots. When one of them is accessed with PHI2 high, the block requests a fixed number of wait cycles. The slow-device strobes are gated by the decoded slow-device select, never by the ready pin, because the CPU itself drives that pin low after a wait-for-interrupt instruction.

Every output is registered on the system clock. Each output reflects the inputs sampled at the previous rising edge. A synchronous active-low reset forces every output to its inactive level.

Top module: `bglue_top`

## Requirements
- R1: Bank-0 selects (ROM, I/O, low RAM) assert only when addr[23:16] is zero. An address with addr[23]=0 and a nonzero bank selects nothing.
- R2: `cs_rom` asserts for 0x00C000..0x00FFFF when vda or vpa is high.
- R3: I/O page 0x00B000..0x00BFFF: addr[11:8] values 0..4 drive `cs_io[0]`..`cs_io[4]`, and values 5..15 select nothing. These selects are qualified by vda alone, so vpa alone selects no I/O slot.
- R4: `cs_ram_lo` asserts for every bank-0 address outside the ROM and the I/O page when vda or vpa is high.
- R5: When addr[23]=1 and vda or vpa is high, addr[22] picks the high module: 0 asserts `cs_hi[0]`, 1 asserts `cs_hi[1]`.
- R6: With vda=vpa=0, every select and `wait_req` are low. PHI2 has no effect on any select.
- R7: `rd_n` is low exactly when phi2=1 and rw=1. `wr_n` is low exactly when phi2=1 and rw=0.
- R8: `slow_rd_n` and `slow_wr_n` follow `rd_n` and `wr_n`, but only while a slow device is selected: ROM, `cs_io[2]` or `cs_io[3]`. They ignore `rdy_in`.
- R9: A slow access sampled with phi2=1 raises `wait_req` on the next cycle for WAIT_CYCLES cycles (default 1). `wait_req` then stays low until phi2 falls, and a later access restarts it. Losing the slow select ends the wait at once.
- R10: `bank_le` is high exactly when phi2=0 and rdy_in=1. `xcvr_en_n` equals `bank_le`, and `xcvr_dir` follows rw.
- R11: While rst_n is low at a clock edge, the outputs take these values:
  - every select and `wait_req` are 0
  - every strobe is 1
  - `bank_le` is 0, `xcvr_en_n` is 1 and `xcvr_dir` is 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 24 | CPU address, bank in [23:16] |
| vda | input | 1 | Data address valid |
| vpa | input | 1 | Program address valid |
| rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | CPU clock phase, 1 = high phase |
| rdy_in | input | 1 | Level of the CPU ready pin |
| cs_rom | output | 1 | Boot ROM select |
| cs_io | output | 5 | I/O slot selects: 0 timer/port device, 1 serial-peripheral controller, 2 dual UART, 3 real-time clock, 4 spare |
| cs_ram_lo | output | 1 | Low RAM select |
| cs_hi | output | 2 | High memory module selects |
| wait_req | output | 1 | Request to hold the ready line low |
| rd_n | output | 1 | Read strobe for fast devices |
| wr_n | output | 1 | Write strobe for fast devices |
| slow_rd_n | output | 1 | Read strobe for wait-stated devices |
| slow_wr_n | output | 1 | Write strobe for wait-stated devices |
| bank_le | output | 1 | Bank-address latch enable |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_dir | output | 1 | Data transceiver direction |

## Verification
Two events can fall in the same cycle: a running wait state and a dead cycle. The bench starts a wait on the clock slot, then drops vda on the cycle the wait is held. It expects `wait_req` and every select low on the next cycle.

A second coincidence is the ready pin held low by the CPU while a slow or a fast device is addressed with PHI2 high. The bench expects the slow read strobe to follow the slow select and not the ready level.

// File: rtl/bglue_pkg.sv
package bglue_pkg;

   localparam int IO_SLOTS = 5;
   localparam int HI_MODS  = 2;

   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_HOLD = 2'd1,
      WS_DONE = 2'd2
   } ws_state_t;

   typedef struct packed {
      logic                rom;
      logic [IO_SLOTS-1:0] io;
      logic                ram_lo;
      logic [HI_MODS-1:0]  hi;
   } sel_t;

endpackage

// File: rtl/bglue_decode.sv
module bglue_decode
   import bglue_pkg::*;
#(
   parameter int                AW           = 24,
   parameter logic [3:0]        IO_PAGE      = 4'hB,
   parameter int                HI_PICK_BIT  = 22,
   parameter logic [IO_SLOTS-1:0] SLOW_IO_MASK = 5'b01100
) (
   input  logic [AW-1:0] addr,
   input  logic          vda,
   input  logic          vpa,
   output sel_t          sel,
   output logic          slow
);
   localparam int BANK_LSB = 16;
   localparam int BANK_W   = AW - BANK_LSB;

   generate
      if (AW <= BANK_LSB + 1) begin : g_bad_aw
         $error("bglue_decode: AW must exceed 17");
      end
      if (IO_PAGE >= 4'hC) begin : g_bad_page
         $error("bglue_decode: IO_PAGE overlaps the ROM");
      end
      if (HI_PICK_BIT < BANK_LSB || HI_PICK_BIT > AW - 2) begin : g_bad_pick
         $error("bglue_decode: HI_PICK_BIT out of the bank field");
      end
   endgenerate

   logic                bank0;
   logic                any_valid;
   logic                rom_hit;
   logic                io_hit;
   logic                ram_hit;
   logic                hi_hit;
   logic [IO_SLOTS-1:0] io_v;
   logic [HI_MODS-1:0]  hi_v;

   assign bank0     = (addr[AW-1:BANK_LSB] == BANK_W'(0));
   assign any_valid = vda | vpa;
   assign rom_hit   = bank0 & addr[15] & addr[14];
   assign io_hit    = bank0 & (addr[15:12] == IO_PAGE);
   assign ram_hit   = bank0 & ~rom_hit & ~io_hit;
   assign hi_hit    = addr[AW-1];

   genvar gi;
   generate
      for (gi = 0; gi < IO_SLOTS; gi++) begin : g_io
         assign io_v[gi] = io_hit & vda & (addr[11:8] == 4'(gi));
      end
      for (gi = 0; gi < HI_MODS; gi++) begin : g_hi
         assign hi_v[gi] = hi_hit & any_valid & (addr[HI_PICK_BIT] == 1'(gi));
      end
   endgenerate

   assign sel = '{rom:    rom_hit & any_valid,
                  io:     io_v,
                  ram_lo: ram_hit & any_valid,
                  hi:     hi_v};

   assign slow = (rom_hit & any_valid) | (|(io_v & SLOW_IO_MASK));

endmodule

// File: rtl/bglue_waitgen.sv
module bglue_waitgen
   import bglue_pkg::*;
#(
   parameter int WAIT_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow,
   input  logic phi2,
   output logic wait_req
);
   localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;

   generate
      if (WAIT_CYCLES < 1 || WAIT_CYCLES > 3) begin : g_bad_wait
         $error("bglue_waitgen: WAIT_CYCLES must be 1..3");
      end
   endgenerate

   ws_state_t state, state_nx;
   logic      last_wait;
   logic      load_cnt;

   generate
      if (WAIT_CYCLES > 1) begin : g_cnt
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (load_cnt)
               cnt <= CW'(WAIT_CYCLES - 1);
            else if (state == WS_HOLD && cnt != '0)
               cnt <= cnt - 1'b1;
         end
         assign last_wait = (cnt == '0);
      end else begin : g_single
         assign last_wait = 1'b1;
      end
   endgenerate

   always_comb begin
      state_nx = state;
      load_cnt = 1'b0;
      case (state)
         WS_IDLE: begin
            if (slow && phi2) begin
               state_nx = WS_HOLD;
               load_cnt = 1'b1;
            end
         end
         WS_HOLD: begin
            if (!slow)
               state_nx = WS_IDLE;
            else if (last_wait)
               state_nx = WS_DONE;
         end
         WS_DONE: begin
            if (!slow || !phi2)
               state_nx = WS_IDLE;
         end
         default: state_nx = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= WS_IDLE;
      else
         state <= state_nx;
   end

   assign wait_req = (state == WS_HOLD);

endmodule

// File: rtl/bglue_strobe.sv
module bglue_strobe (
   input  logic phi2,
   input  logic rw,
   input  logic rdy_in,
   input  logic slow,
   output logic rd_n,
   output logic wr_n,
   output logic slow_rd_n,
   output logic slow_wr_n,
   output logic bank_le,
   output logic xcvr_en_n,
   output logic xcvr_dir
);
   logic rd_phase;
   logic wr_phase;

   assign rd_phase  = phi2 & rw;
   assign wr_phase  = phi2 & ~rw;
   assign rd_n      = ~rd_phase;
   assign wr_n      = ~wr_phase;
   assign slow_rd_n = ~(rd_phase & slow);
   assign slow_wr_n = ~(wr_phase & slow);
   assign bank_le   = ~phi2 & rdy_in;
   assign xcvr_en_n = bank_le;
   assign xcvr_dir  = rw;

endmodule

// File: rtl/bglue_top.sv
module bglue_top
   import bglue_pkg::*;
#(
   parameter int                  AW           = 24,
   parameter logic [3:0]          IO_PAGE      = 4'hB,
   parameter int                  HI_PICK_BIT  = 22,
   parameter logic [IO_SLOTS-1:0] SLOW_IO_MASK = 5'b01100,
   parameter int                  WAIT_CYCLES  = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       addr,
   input  logic                vda,
   input  logic                vpa,
   input  logic                rw,
   input  logic                phi2,
   input  logic                rdy_in,
   output logic                cs_rom,
   output logic [IO_SLOTS-1:0] cs_io,
   output logic                cs_ram_lo,
   output logic [HI_MODS-1:0]  cs_hi,
   output logic                wait_req,
   output logic                rd_n,
   output logic                wr_n,
   output logic                slow_rd_n,
   output logic                slow_wr_n,
   output logic                bank_le,
   output logic                xcvr_en_n,
   output logic                xcvr_dir
);
   sel_t sel_c;
   logic slow_c;
   logic rd_c, wr_c, srd_c, swr_c, le_c, xen_c, xdir_c;

   bglue_decode #(
      .AW(AW), .IO_PAGE(IO_PAGE), .HI_PICK_BIT(HI_PICK_BIT),
      .SLOW_IO_MASK(SLOW_IO_MASK)
   ) u_decode (
      .addr(addr), .vda(vda), .vpa(vpa), .sel(sel_c), .slow(slow_c)
   );

   bglue_waitgen #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
      .clk(clk), .rst_n(rst_n), .slow(slow_c), .phi2(phi2), .wait_req(wait_req)
   );

   bglue_strobe u_strobe (
      .phi2(phi2), .rw(rw), .rdy_in(rdy_in), .slow(slow_c),
      .rd_n(rd_c), .wr_n(wr_c), .slow_rd_n(srd_c), .slow_wr_n(swr_c),
      .bank_le(le_c), .xcvr_en_n(xen_c), .xcvr_dir(xdir_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_rom    <= 1'b0;
         cs_io     <= '0;
         cs_ram_lo <= 1'b0;
         cs_hi     <= '0;
         rd_n      <= 1'b1;
         wr_n      <= 1'b1;
         slow_rd_n <= 1'b1;
         slow_wr_n <= 1'b1;
         bank_le   <= 1'b0;
         xcvr_en_n <= 1'b1;
         xcvr_dir  <= 1'b1;
      end else begin
         cs_rom    <= sel_c.rom;
         cs_io     <= sel_c.io;
         cs_ram_lo <= sel_c.ram_lo;
         cs_hi     <= sel_c.hi;
         rd_n      <= rd_c;
         wr_n      <= wr_c;
         slow_rd_n <= srd_c;
         slow_wr_n <= swr_c;
         bank_le   <= le_c;
         xcvr_en_n <= xen_c;
         xcvr_dir  <= xdir_c;
      end
   end

endmodule

// File: rtl/bglue_chk.sv
module bglue_chk
   import bglue_pkg::*;
#(
   parameter logic [IO_SLOTS-1:0] SLOW_IO_MASK = 5'b01100
) (
   input logic                clk,
   input logic                rst_n,
   input logic                vda,
   input logic                vpa,
   input logic                phi2,
   input logic                rdy_in,
   input logic                cs_rom,
   input logic [IO_SLOTS-1:0] cs_io,
   input logic                cs_ram_lo,
   input logic [HI_MODS-1:0]  cs_hi,
   input logic                wait_req,
   input logic                rd_n,
   input logic                wr_n,
   input logic                slow_rd_n,
   input logic                slow_wr_n,
   input logic                bank_le,
   input logic                xcvr_en_n
);
   logic any_cs;
   logic slow_cs;
   logic was_rst;

   assign any_cs  = cs_rom | (|cs_io) | cs_ram_lo | (|cs_hi);
   assign slow_cs = cs_rom | (|(cs_io & SLOW_IO_MASK));

   // R1
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_rom, cs_io, cs_ram_lo, cs_hi}));

   // R6
   sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_cs |-> $past(vda | vpa));

   // R3
   io_vda_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|cs_io) |-> $past(vda));

   // R9
   wait_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_req |-> slow_cs);

   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R8
   slow_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!slow_rd_n || !slow_wr_n) |-> (slow_cs && (!rd_n || !wr_n)));

   // R10
   bank_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_le |-> ($past(!phi2 && rdy_in) && xcvr_en_n));

   always_ff @(posedge clk) was_rst <= !rst_n;

   // R11
   always @(negedge clk) begin
      if (was_rst === 1'b1 && rst_n === 1'b1) begin
         reset_idle_chk: assert (!any_cs && !wait_req && rd_n && wr_n &&
                                 slow_rd_n && slow_wr_n && !bank_le);
      end
   end

endmodule

bind bglue_top bglue_chk #(.SLOW_IO_MASK(SLOW_IO_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .vda(vda), .vpa(vpa), .phi2(phi2),
   .rdy_in(rdy_in), .cs_rom(cs_rom), .cs_io(cs_io), .cs_ram_lo(cs_ram_lo),
   .cs_hi(cs_hi), .wait_req(wait_req), .rd_n(rd_n), .wr_n(wr_n),
   .slow_rd_n(slow_rd_n), .slow_wr_n(slow_wr_n), .bank_le(bank_le),
   .xcvr_en_n(xcvr_en_n)
);

// File: tb/bglue_top_tb.sv
module bglue_top_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [23:0] addr;
   logic        vda, vpa, rw, phi2, rdy_in;
   logic        cs_rom, cs_ram_lo, wait_req;
   logic [4:0]  cs_io;
   logic [1:0]  cs_hi;
   logic        rd_n, wr_n, slow_rd_n, slow_wr_n, bank_le, xcvr_en_n, xcvr_dir;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   bglue_top u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .vda(vda), .vpa(vpa), .rw(rw),
      .phi2(phi2), .rdy_in(rdy_in), .cs_rom(cs_rom), .cs_io(cs_io),
      .cs_ram_lo(cs_ram_lo), .cs_hi(cs_hi), .wait_req(wait_req),
      .rd_n(rd_n), .wr_n(wr_n), .slow_rd_n(slow_rd_n), .slow_wr_n(slow_wr_n),
      .bank_le(bank_le), .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir)
   );

   // selects packed as {rom, io[4:0], ram_lo, hi[1:0]}
   localparam logic [8:0] S_NONE = 9'b0_00000_0_00;
   localparam logic [8:0] S_ROM  = 9'b1_00000_0_00;
   localparam logic [8:0] S_RAM  = 9'b0_00000_1_00;
   localparam logic [8:0] S_HI0  = 9'b0_00000_0_01;
   localparam logic [8:0] S_HI1  = 9'b0_00000_0_10;

   function automatic logic [8:0] s_io(input int slot);
      logic [4:0] v = 5'b0;
      v[slot] = 1'b1;
      return {1'b0, v, 3'b000};
   endfunction

   function automatic logic [8:0] sels();
      return {cs_rom, cs_io, cs_ram_lo, cs_hi};
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic drv(input logic [23:0] a, input logic d, input logic p,
                      input logic r, input logic ph, input logic rd);
      addr = a; vda = d; vpa = p; rw = r; phi2 = ph; rdy_in = rd;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      drv(24'h00C123, 1, 1, 0, 1, 1);
      drv(24'h00C123, 1, 1, 0, 1, 1);
      chk("R11 selects", 16'(sels()), 16'(S_NONE));
      chk("R11 wait", 16'(wait_req), 16'd0);
      chk("R11 strobes", 16'({rd_n, wr_n, slow_rd_n, slow_wr_n}), 16'hF);
      chk("R11 bus ctl", 16'({bank_le, xcvr_en_n, xcvr_dir}), 16'b011);
      rst_n = 1'b1;
   endtask

   task automatic t_bank0();
      drv(24'h00C000, 1, 0, 1, 0, 1); chk("R2 rom low edge", 16'(sels()), 16'(S_ROM));
      drv(24'h00FFFF, 0, 1, 1, 0, 1); chk("R2 rom vpa", 16'(sels()), 16'(S_ROM));
      drv(24'h000200, 1, 0, 1, 0, 1); chk("R4 ram", 16'(sels()), 16'(S_RAM));
      drv(24'h00AFFF, 0, 1, 1, 0, 1); chk("R4 ram below io", 16'(sels()), 16'(S_RAM));
      drv(24'h01C000, 1, 1, 1, 0, 1); chk("R1 bank 1", 16'(sels()), 16'(S_NONE));
      drv(24'h400000, 1, 1, 1, 0, 1); chk("R1 mid bank", 16'(sels()), 16'(S_NONE));
   endtask

   task automatic t_io();
      for (int s = 0; s < 5; s++) begin
         drv(24'h00B000 | (24'(s) << 8) | 24'h5A, 1, 0, 1, 0, 1);
         chk("R3 io slot", 16'(sels()), 16'(s_io(s)));
      end
      drv(24'h00B500, 1, 0, 1, 0, 1); chk("R3 empty slot", 16'(sels()), 16'(S_NONE));
      drv(24'h00BF00, 1, 1, 1, 0, 1); chk("R3 top slot", 16'(sels()), 16'(S_NONE));
      drv(24'h00B100, 0, 1, 1, 0, 1); chk("R3 vpa only", 16'(sels()), 16'(S_NONE));
   endtask

   task automatic t_high();
      drv(24'h800000, 1, 0, 1, 0, 1); chk("R5 module 0", 16'(sels()), 16'(S_HI0));
      drv(24'hC12345, 0, 1, 1, 0, 1); chk("R5 module 1", 16'(sels()), 16'(S_HI1));
      drv(24'hBFFFFF, 1, 1, 1, 0, 1); chk("R5 module 0 top", 16'(sels()), 16'(S_HI0));
   endtask

   task automatic t_dead();
      drv(24'h00C000, 0, 0, 1, 1, 1);
      chk("R6 dead rom", 16'({sels(), wait_req}), 16'd0);
      drv(24'h00B300, 0, 0, 1, 1, 1);
      chk("R6 dead rtc", 16'({sels(), wait_req}), 16'd0);
      drv(24'hC00000, 0, 0, 1, 1, 1);
      chk("R6 dead hi", 16'(sels()), 16'(S_NONE));
      drv(24'h00C000, 1, 0, 1, 1, 1); chk("R6 phi2 high", 16'(sels()), 16'(S_ROM));
      drv(24'h00C000, 1, 0, 1, 0, 1); chk("R6 phi2 low", 16'(sels()), 16'(S_ROM));
   endtask

   task automatic t_strobe();
      drv(24'h000100, 1, 0, 1, 1, 1);
      chk("R7 read", 16'({rd_n, wr_n}), 16'b01);
      drv(24'h000100, 1, 0, 0, 1, 1);
      chk("R7 write", 16'({rd_n, wr_n}), 16'b10);
      drv(24'h000100, 1, 0, 0, 0, 1);
      chk("R7 phi2 low", 16'({rd_n, wr_n}), 16'b11);
      drv(24'h000100, 1, 0, 1, 1, 0);
      chk("R8 fast dev rdy low", 16'({rd_n, slow_rd_n, slow_wr_n}), 16'b011);
      drv(24'h00B200, 1, 0, 1, 1, 0);
      chk("R8 duart read rdy low", 16'({slow_rd_n, slow_wr_n}), 16'b01);
      drv(24'h00B200, 1, 0, 1, 0, 1);
      drv(24'h00E000, 1, 0, 0, 1, 1);
      chk("R8 rom write", 16'({slow_rd_n, slow_wr_n}), 16'b10);
      drv(24'h00B000, 1, 0, 1, 1, 1);
      chk("R8 via no slow", 16'({rd_n, slow_rd_n}), 16'b01);
      drv(24'h00B000, 1, 0, 1, 0, 1);
   endtask

   task automatic t_wait();
      drv(24'h00B300, 1, 0, 1, 0, 1); chk("R9 phi2 low no wait", 16'(wait_req), 16'd0);
      drv(24'h00B300, 1, 0, 1, 1, 1); chk("R9 rtc wait on", 16'(wait_req), 16'd1);
      drv(24'h00B300, 1, 0, 1, 1, 0); chk("R9 wait released", 16'(wait_req), 16'd0);
      drv(24'h00B300, 1, 0, 1, 1, 1); chk("R9 stays released", 16'(wait_req), 16'd0);
      drv(24'h00B300, 1, 0, 1, 0, 1); chk("R9 phi2 fell", 16'(wait_req), 16'd0);
      drv(24'h00B300, 1, 0, 1, 1, 1); chk("R9 restart", 16'(wait_req), 16'd1);
      drv(24'h00B300, 0, 0, 1, 1, 1);
      chk("R6 dead cycle ends wait", 16'({sels(), wait_req}), 16'd0);
      drv(24'h00B000, 1, 0, 1, 1, 1); chk("R9 via no wait", 16'(wait_req), 16'd0);
      drv(24'h00B000, 1, 0, 1, 0, 1);
      drv(24'h00D000, 0, 1, 1, 1, 1); chk("R9 rom fetch wait", 16'(wait_req), 16'd1);
      drv(24'h00D000, 0, 1, 1, 0, 1);
      drv(24'h00D000, 0, 0, 1, 1, 1); chk("R9 rom dead no wait", 16'(wait_req), 16'd0);
   endtask

   task automatic t_busctl();
      drv(24'h000000, 1, 0, 1, 0, 1);
      chk("R10 le open", 16'({bank_le, xcvr_en_n, xcvr_dir}), 16'b111);
      drv(24'h000000, 1, 0, 0, 0, 0);
      chk("R10 rdy low", 16'({bank_le, xcvr_en_n, xcvr_dir}), 16'b000);
      drv(24'h000000, 1, 0, 0, 1, 1);
      chk("R10 phi2 high", 16'({bank_le, xcvr_en_n, xcvr_dir}), 16'b000);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      rst_n = 1'b0; addr = '0; vda = 0; vpa = 0; rw = 1; phi2 = 0; rdy_in = 1;
      @(negedge clk);
      t_reset();
      t_bank0();
      t_io();
      t_high();
      t_dead();
      t_strobe();
      t_wait();
      t_busctl();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule